// File: doc/BRIEF.md
# IR Pulse Width Capture

This block times the high and low intervals of an already demodulated infrared envelope. Each time the envelope changes level, the block stores the length of the interval that just ended, together with its level, in a small receive queue. A host drains the queue through a read strobe. Width is counted in units of four prescaled reference clocks, so one programmable divider sets both the resolution and the longest interval that can be measured.

A glitch filter in front of the timer drops level changes that are too short. If no edge arrives before the width counter runs out, the measurement stops with a timeout. A control input selects whether a timeout also writes a marker entry. Four status outputs cover timeout, overrun, measurement in progress and queue service request. An interrupt line combines the enabled ones. The queue threshold that raises a service request can be selected.

Top module: `ir_pulse_capture`

## Requirements
- R1: A queue entry presented on `rdData` holds the width count in bits CNT_W-1:0 (15:0 at default), the interval level in bit CNT_W (1 = envelope high) and a valid flag in bit CNT_W+1.
- R2: While the queue is empty, `rdData` is all zeros with the valid bit clear. A read strobe on an empty queue changes nothing.
- R3: The queue holds DEPTH (8) entries and returns them in the order they were written.
- R4: After `enable`, the first accepted edge only starts a measurement. Each later accepted edge writes one entry whose width is floor(N / (4*(divider+1))), where N is the interval length in reference clocks.
- R5: If the width count is already at all ones and another unit elapses with no edge, `flagTimeout` is set and `flagBusy` clears. When `markerOnTimeout` is 1, an entry with all-ones width and level 1 is written; otherwise nothing is written. An interval of one clock less than that limit is stored as the all-ones width with no timeout. The next edge starts a new measurement.
- R6: A level change is accepted only after it has held for `filterCount` consecutive clocks, so shorter pulses merge into the surrounding interval. A `filterCount` of 0 accepts every change.
- R7: A write while the queue is full, with no read in the same cycle, is dropped and sets the sticky `flagOverrun`.
- R8: A `statusRead` pulse clears `flagTimeout` and `flagOverrun`.
- R9: `flagBusy` is 1 while a measurement runs and is 0 whenever `enable` is low. While `enable` is low, edges write nothing.
- R10: With `waterHalf` at 0, `flagService` means the queue is not empty. With `waterHalf` at 1, it means the queue holds at least DEPTH/2 entries.
- R11: `irq` is high when any of timeout, overrun or service is set together with its own enable input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable |
| envIn | input | 1 | Demodulated envelope, 1 = mark |
| divider | input | DIV_W | Prescale value; one width unit is 4*(divider+1) clocks |
| filterCount | input | FILT_W | Minimum accepted pulse length in clocks; 0 turns the filter off |
| markerOnTimeout | input | 1 | On a timeout, write an all-ones marker entry |
| waterHalf | input | 1 | Service threshold: 0 = not empty, 1 = half full |
| irqEnTimeout | input | 1 | Interrupt enable for timeout |
| irqEnOverrun | input | 1 | Interrupt enable for overrun |
| irqEnService | input | 1 | Interrupt enable for service request |
| rdStrobe | input | 1 | Pops the head entry |
| statusRead | input | 1 | Clears the sticky flags |
| rdData | output | CNT_W+2 | Head entry: valid, level, width |
| flagTimeout | output | 1 | Sticky timeout flag |
| flagOverrun | output | 1 | Sticky overrun flag |
| flagBusy | output | 1 | Measurement in progress |
| flagService | output | 1 | Queue needs service |
| irq | output | 1 | Combined interrupt |

## Verification
The bench aims at the rounding of the width at two divider values. A timer that is off by one clock would store widths one unit short whenever an interval is an exact multiple of the unit. It also drives filter pulses one clock below and exactly at `filterCount`: a filter that compares with the wrong bound either splits a merged mark or swallows a valid one. The timeout limit is tested one clock short and well past, with and without the marker, to catch a timer that fires early or writes a marker it should not. The queue is filled to nine writes, which exposes a design that overwrites the oldest entry instead of dropping the new one, or that misplaces the half-full threshold.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

  // Strobes from the control to the datapath, valid for one cycle
  typedef struct packed {
    logic startMeas;   // first accepted edge after enable
    logic pushEdge;    // accepted edge closes an interval
    logic timeout;     // width counter ran past its top value
    logic pushMarker;  // timeout with marker write requested
  } capStrobes_t;

endpackage

// File: rtl/ir_cap_ctrl.sv
module ir_cap_ctrl
  import ir_cap_pkg::*;
#(
  parameter int FILT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              envIn,
  input  logic [FILT_W-1:0] filterCount,
  input  logic              markerOnTimeout,
  input  logic              tick,
  input  logic              widthSat,
  output capStrobes_t       stb,
  output logic              filtLevel,
  output logic              busy
);

  logic              envQ;
  logic [FILT_W-1:0] glitchCnt;
  logic [FILT_W:0]   glitchNext;
  logic              mismatch;
  logic              filterOff;
  logic              accept;

  always_comb begin
    mismatch   = envQ ^ filtLevel;
    filterOff  = (filterCount == '0);
    glitchNext = {1'b0, glitchCnt} + (FILT_W+1)'(1);
    accept     = mismatch && (filterOff || (glitchNext >= {1'b0, filterCount}));
  end

  // Input register and glitch filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      envQ      <= 1'b0;
      filtLevel <= 1'b0;
      glitchCnt <= '0;
    end else begin
      envQ <= envIn;
      if (accept) begin
        filtLevel <= envQ;
        glitchCnt <= '0;
      end else if (!mismatch) begin
        glitchCnt <= '0;
      end else begin
        glitchCnt <= glitchNext[FILT_W-1:0];
      end
    end
  end

  always_comb begin
    stb.startMeas  = accept && enable && !busy;
    stb.pushEdge   = accept && enable && busy;
    stb.timeout    = enable && busy && !accept && tick && widthSat;
    stb.pushMarker = enable && busy && !accept && tick && widthSat && markerOnTimeout;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (!enable) begin
      busy <= 1'b0;
    end else if (stb.startMeas) begin
      busy <= 1'b1;
    end else if (stb.timeout) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/ir_cap_fifo.sv
module ir_cap_fifo #(
  parameter int ENT_W = 17,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  logic [ENT_W-1:0]              pushData,
  input  logic                          pop,
  output logic [ENT_W-1:0]              headData,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          dropped
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic             full;
  logic             popOk;
  logic             pushOk;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    full     = (count == CW'(DEPTH));
    popOk    = pop && (count != '0);
    pushOk   = push && (!full || popOk);
    dropped  = push && !pushOk;
    headData = mem[rdPtr];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (pushOk && (wrPtr == AW'(i))) begin
        mem[i] <= pushData;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/ir_cap_datapath.sv
module ir_cap_datapath
  import ir_cap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16,
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  capStrobes_t                   stb,
  input  logic                          busy,
  input  logic                          curLevel,
  input  logic [DIV_W-1:0]              divider,
  input  logic                          rdStrobe,
  input  logic                          statusRead,
  input  logic                          waterHalf,
  output logic                          tick,
  output logic                          widthSat,
  output logic [CNT_W+1:0]              rdData,
  output logic [$clog2(DEPTH+1)-1:0]    fifoCount,
  output logic                          flagTimeout,
  output logic                          flagOverrun,
  output logic                          flagService
);

  localparam int PW    = DIV_W + 2;
  localparam int ENT_W = CNT_W + 1;
  localparam int CW    = $clog2(DEPTH+1);

  logic [PW-1:0]    presc;
  logic [PW-1:0]    prescLimit;
  logic [CNT_W-1:0] width;
  logic [CNT_W-1:0] widthNext;
  logic             restart;
  logic             pushAny;
  logic [ENT_W-1:0] pushData;
  logic [ENT_W-1:0] headData;
  logic             dropped;

  // Width timer: one unit per 4*(divider+1) clocks
  always_comb begin
    prescLimit = {divider, 2'b11};
    tick       = busy && (presc == prescLimit);
    widthSat   = &width;
    widthNext  = (tick && !widthSat) ? width + CNT_W'(1) : width;
    restart    = stb.startMeas || stb.pushEdge || !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      width <= '0;
    end else if (restart) begin
      presc <= '0;
      width <= '0;
    end else begin
      presc <= tick ? '0 : presc + PW'(1);
      width <= widthNext;
    end
  end

  always_comb begin
    pushAny  = stb.pushEdge || stb.pushMarker;
    pushData = stb.pushMarker ? '1 : {curLevel, widthNext};
  end

  ir_cap_fifo #(
    .ENT_W(ENT_W),
    .DEPTH(DEPTH)
  ) fifoInst (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (pushAny),
    .pushData (pushData),
    .pop      (rdStrobe),
    .headData (headData),
    .count    (fifoCount),
    .dropped  (dropped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagTimeout <= 1'b0;
      flagOverrun <= 1'b0;
    end else begin
      if (stb.timeout)     flagTimeout <= 1'b1;
      else if (statusRead) flagTimeout <= 1'b0;
      if (dropped)         flagOverrun <= 1'b1;
      else if (statusRead) flagOverrun <= 1'b0;
    end
  end

  always_comb begin
    rdData      = (fifoCount != '0) ? {1'b1, headData} : '0;
    flagService = waterHalf ? (fifoCount >= CW'(DEPTH/2)) : (fifoCount != '0);
  end

endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
  import ir_cap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int FILT_W = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              envIn,
  input  logic [DIV_W-1:0]  divider,
  input  logic [FILT_W-1:0] filterCount,
  input  logic              markerOnTimeout,
  input  logic              waterHalf,
  input  logic              irqEnTimeout,
  input  logic              irqEnOverrun,
  input  logic              irqEnService,
  input  logic              rdStrobe,
  input  logic              statusRead,
  output logic [CNT_W+1:0]  rdData,
  output logic              flagTimeout,
  output logic              flagOverrun,
  output logic              flagBusy,
  output logic              flagService,
  output logic              irq
);

  capStrobes_t                 stb;
  logic                        tick;
  logic                        widthSat;
  logic                        filtLevel;
  logic [$clog2(DEPTH+1)-1:0]  fifoCount;
  logic                        pushAny;

  ir_cap_ctrl #(
    .FILT_W(FILT_W)
  ) ctrlInst (
    .clk             (clk),
    .rst_n           (rst_n),
    .enable          (enable),
    .envIn           (envIn),
    .filterCount     (filterCount),
    .markerOnTimeout (markerOnTimeout),
    .tick            (tick),
    .widthSat        (widthSat),
    .stb             (stb),
    .filtLevel       (filtLevel),
    .busy            (flagBusy)
  );

  ir_cap_datapath #(
    .CNT_W(CNT_W),
    .DIV_W(DIV_W),
    .DEPTH(DEPTH)
  ) dpInst (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .busy        (flagBusy),
    .curLevel    (filtLevel),
    .divider     (divider),
    .rdStrobe    (rdStrobe),
    .statusRead  (statusRead),
    .waterHalf   (waterHalf),
    .tick        (tick),
    .widthSat    (widthSat),
    .rdData      (rdData),
    .fifoCount   (fifoCount),
    .flagTimeout (flagTimeout),
    .flagOverrun (flagOverrun),
    .flagService (flagService)
  );

  assign pushAny = stb.pushEdge | stb.pushMarker;
  assign irq = (flagTimeout & irqEnTimeout) | (flagOverrun & irqEnOverrun) |
               (flagService & irqEnService);

endmodule

// File: rtl/ir_cap_checker.sv
module ir_cap_checker #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       enable,
  input logic                       waterHalf,
  input logic                       irqEnTimeout,
  input logic                       irqEnOverrun,
  input logic                       irqEnService,
  input logic                       rdStrobe,
  input logic                       statusRead,
  input logic [CNT_W+1:0]           rdData,
  input logic                       flagTimeout,
  input logic                       flagOverrun,
  input logic                       flagBusy,
  input logic                       flagService,
  input logic                       irq,
  input logic [$clog2(DEPTH+1)-1:0] fifoCount,
  input logic                       pushAny,
  input logic                       stbTimeout
);

  // R2
  empty_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoCount == 0) |-> !rdData[CNT_W+1]);

  // R3
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifoCount <= DEPTH);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoCount == DEPTH && pushAny && !rdStrobe) |=> flagOverrun);

  // R7
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagOverrun && !statusRead) |=> flagOverrun);

  // R8
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (statusRead && !stbTimeout) |=> !flagTimeout);

  // R5
  timeout_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flagTimeout) |-> !flagBusy);

  // R9
  busy_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !flagBusy);

  // R10
  svc_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!waterHalf && rdData[CNT_W+1]) |-> flagService);

  // R11
  irq_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagTimeout && irqEnTimeout) |-> irq);

  // R11
  irq_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagOverrun && irqEnOverrun) |-> irq);

  // R11
  irq_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flagService && irqEnService) |-> irq);

endmodule

bind ir_pulse_capture ir_cap_checker #(
  .CNT_W(CNT_W),
  .DEPTH(DEPTH)
) chkInst (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .waterHalf    (waterHalf),
  .irqEnTimeout (irqEnTimeout),
  .irqEnOverrun (irqEnOverrun),
  .irqEnService (irqEnService),
  .rdStrobe     (rdStrobe),
  .statusRead   (statusRead),
  .rdData       (rdData),
  .flagTimeout  (flagTimeout),
  .flagOverrun  (flagOverrun),
  .flagBusy     (flagBusy),
  .flagService  (flagService),
  .irq          (irq),
  .fifoCount    (fifoCount),
  .pushAny      (pushAny),
  .stbTimeout   (stb.timeout)
);

// File: tb/ir_pulse_capture_test.sv
module ir_pulse_capture_test;

  localparam int CW    = 8;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          envIn = 1'b0;
  logic [15:0]   divider = '0;
  logic [15:0]   filterCount = '0;
  logic          markerOnTimeout = 1'b0;
  logic          waterHalf = 1'b0;
  logic          irqEnTimeout = 1'b0;
  logic          irqEnOverrun = 1'b0;
  logic          irqEnService = 1'b0;
  logic          monRd = 1'b0;
  logic          manRd = 1'b0;
  logic          rdStrobe;
  logic          statusRead = 1'b0;
  logic [CW+1:0] rdData;
  logic          flagTimeout, flagOverrun, flagBusy, flagService, irq;

  int total = 0;
  int bad = 0;
  bit monOn = 1'b1;
  logic [CW:0] expQ[$];
  string       tagQ[$];

  assign rdStrobe = monRd | manRd;

  always #4 clk = ~clk;

  ir_pulse_capture #(.CNT_W(CW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .envIn(envIn),
    .divider(divider), .filterCount(filterCount),
    .markerOnTimeout(markerOnTimeout), .waterHalf(waterHalf),
    .irqEnTimeout(irqEnTimeout), .irqEnOverrun(irqEnOverrun),
    .irqEnService(irqEnService), .rdStrobe(rdStrobe),
    .statusRead(statusRead), .rdData(rdData),
    .flagTimeout(flagTimeout), .flagOverrun(flagOverrun),
    .flagBusy(flagBusy), .flagService(flagService), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_entry(input logic lvl, input int w, input string tag);
    expQ.push_back({lvl, CW'(w)});
    tagQ.push_back(tag);
  endtask

  task automatic drive(input logic lvl, input int n);
    envIn = lvl;
    repeat (n) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStatus();
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic readOne(input int exp, input string tag);
    chk(tag, rdData, exp);
    manRd = 1'b1;
    @(negedge clk);
    manRd = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && expQ.size() != 0; i++) @(negedge clk);
    chk("R3 queue drained", expQ.size(), 0);
  endtask

  // Monitor: pops expected entries and compares as the design produces them
  initial begin
    forever begin
      @(negedge clk);
      if (monOn && rst_n && rdData[CW+1]) begin
        if (expQ.size() == 0) begin
          total++;
          bad++;
          $display("FAIL R3 unexpected entry actual=%0h expected=none", rdData);
        end else begin
          logic [CW:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(t, rdData[CW:0], e);
        end
        monRd = 1'b1;
        @(negedge clk);
        monRd = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // Reset state
    chk("R2 reset rdData", rdData, 0);
    chk("R5 reset timeout", flagTimeout, 0);
    chk("R7 reset overrun", flagOverrun, 0);
    chk("R9 reset busy", flagBusy, 0);
    chk("R11 reset irq", irq, 0);

    // Widths at unit of 4 clocks, filter off (R4, R6 zero filter)
    divider = 16'd0;
    enable = 1'b1;
    idle(5);
    expect_entry(1, 10, "R4 mark 40");
    drive(1, 40);
    chk("R9 busy while measuring", flagBusy, 1);
    expect_entry(0, 9, "R4 space 37");
    drive(0, 37);
    expect_entry(1, 0, "R6 short pulse with filter off");
    drive(1, 3);
    expect_entry(0, 1, "R4 space 5");
    drive(0, 5);
    expect_entry(1, 10, "R1 level bit mark 43");
    drive(1, 43);
    drive(0, 20);
    enable = 1'b0;
    idle(2);
    chk("R9 busy clear when disabled", flagBusy, 0);
    drain();

    // Unit of 12 clocks (R4)
    divider = 16'd2;
    enable = 1'b1;
    idle(3);
    expect_entry(1, 4, "R4 div2 50");
    drive(1, 50);
    expect_entry(0, 3, "R4 div2 36");
    drive(0, 36);
    expect_entry(1, 0, "R4 div2 11");
    drive(1, 11);
    expect_entry(0, 16, "R4 div2 200");
    drive(0, 200);
    drive(1, 20);
    enable = 1'b0;
    idle(2);
    drain();

    // Glitch filter of 5 clocks (R6)
    divider = 16'd0;
    filterCount = 16'd5;
    enable = 1'b1;
    idle(10);
    expect_entry(0, 16, "R6 glitch of 4 merged");
    drive(0, 30);
    drive(1, 4);
    drive(0, 30);
    expect_entry(1, 10, "R6 mark after glitch");
    drive(1, 40);
    expect_entry(0, 1, "R6 pulse at filter length kept");
    drive(0, 5);
    drive(1, 30);
    enable = 1'b0;
    idle(2);
    drain();
    filterCount = 16'd0;

    // Timeout boundary and marker (R5)
    markerOnTimeout = 1'b1;
    irqEnTimeout = 1'b1;
    enable = 1'b1;
    idle(5);
    expect_entry(0, 255, "R5 one clock below limit");
    drive(0, 1023);
    expect_entry(1, 255, "R5 timeout marker");
    drive(1, 10);
    chk("R5 no timeout below limit", flagTimeout, 0);
    drive(1, 1090);
    chk("R5 timeout flag", flagTimeout, 1);
    chk("R5 busy cleared by timeout", flagBusy, 0);
    chk("R11 irq from timeout", irq, 1);
    pulseStatus();
    chk("R8 timeout cleared", flagTimeout, 0);
    chk("R11 irq dropped", irq, 0);
    expect_entry(0, 10, "R5 restart after timeout");
    drive(0, 40);
    drive(1, 20);
    enable = 1'b0;
    idle(2);
    drain();
    irqEnTimeout = 1'b0;

    // Timeout without marker (R5)
    markerOnTimeout = 1'b0;
    enable = 1'b1;
    idle(3);
    drive(0, 1100);
    chk("R5 timeout without marker", flagTimeout, 1);
    chk("R5 no marker written", rdData, 0);
    pulseStatus();
    enable = 1'b0;
    idle(3);

    // Overrun and watermark, manual reads (R3, R7, R10)
    monOn = 1'b0;
    irqEnOverrun = 1'b1;
    enable = 1'b1;
    idle(3);
    for (int i = 0; i < 10; i++) drive((i % 2 == 0) ? 1'b1 : 1'b0, 20);
    enable = 1'b0;
    idle(3);
    chk("R7 overrun set", flagOverrun, 1);
    chk("R11 irq from overrun", irq, 1);
    waterHalf = 1'b1;
    idle(1);
    chk("R10 half threshold full", flagService, 1);
    pulseStatus();
    chk("R8 overrun cleared", flagOverrun, 0);
    chk("R11 irq after clear", irq, 0);
    for (int k = 0; k < DEPTH; k++) begin
      logic lvl;
      lvl = (k % 2 == 0) ? 1'b1 : 1'b0;
      if (k == 4) chk("R10 four entries at half", flagService, 1);
      if (k == 5) begin
        chk("R10 three entries below half", flagService, 0);
        waterHalf = 1'b0;
        irqEnService = 1'b1;
        idle(1);
        chk("R10 not-empty threshold", flagService, 1);
        chk("R11 irq from service", irq, 1);
        irqEnService = 1'b0;
        waterHalf = 1'b1;
      end
      readOne({1'b1, lvl, CW'(5)}, "R3 order and drop of ninth");
    end
    chk("R2 empty after drain", rdData, 0);
    readOne(0, "R2 read of empty queue");
    chk("R2 empty stays empty", rdData, 0);
    waterHalf = 1'b0;
    irqEnOverrun = 1'b0;
    monOn = 1'b1;

    // Disabled receiver ignores edges (R9)
    drive(1, 20);
    drive(0, 20);
    drive(1, 20);
    chk("R9 no entry while disabled", rdData, 0);
    chk("R9 busy low while disabled", flagBusy, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule